// File: doc/BRIEF.md
# Byte-Port Packet Interface

This block is a small network interface that a host drives entirely through a register window. Frames pass between the host and the network one byte per register access. The block keeps one receive frame store and one transmit frame store. A register bank reports identity, a busy indication and the byte counts, and holds three interrupt flags that drive one level-sensitive interrupt line. Acknowledges are write-one with a fixed priority. One flag is a self-test bit: setting it soft-resets the device, and reading it clears it.

Incoming frames arrive on a byte stream that carries first and last markers. The block captures a frame only when it is idle with room to spare, and it commits the frame only at the last byte. Outgoing frames leave on a byte stream with the same markers once the host has written the programmed number of bytes.

Top module: `bytewise_nic`

## Requirements
- R1: Only the low six address bits are decoded, so offset 0x40 aliases 0x00. Offset 0x00 reads 0x4E494331 and offset 0x04 reads 0x42595445.
- R2: Offsets 0x18, 0x20 and every unmapped offset read zero. Writes to 0x00, 0x04, 0x08, 0x0C, 0x18 and 0x1C change nothing.
- R3: `rxs_ready` is high exactly when busy is clear and the receive count (0x0C) is below 1514. It is sampled only on the first byte of a frame, and a frame refused there is dropped in full.
- R4: A captured frame of length below 1514 is committed at its last byte. The commit loads the receive count with the length, rewinds the read index, sets busy (0x08) and sets receive-done (bit 1 of 0x14). A frame of 1514 bytes or more leaves every state unchanged.
- R5: A read of 0x1C with a nonzero receive count returns the next stored byte in bits 7:0, with zeros above, and decrements the count. With a zero count the read returns zero and changes nothing.
- R6: A write to 0x10 loads the transmit count with the written value if that value is at most 1514, and with zero otherwise. The write also rewinds the transmit write index.
- R7: A write to 0x20 stores bits 7:0 and advances the write index. When the index equals the transmit count or reaches 1514, the frame is sent, both transmit counters clear, transmit-done (bit 0) sets and busy sets.
- R8: A sent frame appears on `txs_*` one byte per cycle, in write order. `txs_first` is high on the first byte and `txs_last` on the final byte.
- R9: A write to 0x14 acts on one bit, in priority order: bit 0 clears transmit-done; otherwise bit 1 clears receive-done; otherwise bit 31 soft-resets all counters and flags and then sets the test flag (bit 31). A write of zero changes no flag.
- R10: Busy is 1 after reset. After any write to 0x14, busy is 1 exactly when some flag is still set.
- R11: A read of 0x14 returns the flags as they were and clears the test flag.
- R12: `irq` is high whenever any flag in 0x14 is set.
- R13: A receive commit wins over a simultaneous flag write and over a simultaneous 0x1C read. After the commit, receive-done and busy are set, the count equals the new length, and later reads start at the new frame's first byte.
- R14: Read data appears on `bus_rdata` in the cycle after the read strobe. Each strobe cycle applies its side effect once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | BUS_AW | Register address; only the low six bits are decoded |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle after the strobe |
| irq | output | 1 | Level interrupt, high while any flag is set |
| rxs_valid | input | 1 | Receive stream byte valid |
| rxs_first | input | 1 | Marks the first byte of a received frame |
| rxs_last | input | 1 | Marks the last byte of a received frame |
| rxs_data | input | 8 | Receive stream byte |
| rxs_ready | output | 1 | Accept condition, sampled on first bytes |
| txs_valid | output | 1 | Transmit stream byte valid |
| txs_first | output | 1 | Marks the first byte of a sent frame |
| txs_last | output | 1 | Marks the last byte of a sent frame |
| txs_data | output | 8 | Transmit stream byte |

## Verification
The collision that matters is a receive commit landing in the same cycle as a host access. The bench starts a receive frame while the block is idle and completes a transmit frame during its capture, so busy rises after the frame was already accepted. It then times the final receive byte to coincide with a transmit-done acknowledge, and expects receive-done set, transmit-done clear and busy high. A second run puts the final byte on the same cycle as a data-port read, and is judged by the count reading the new length and by the next reads returning the new frame from its first byte.

// File: rtl/bnic_pkg.sv
package bnic_pkg;
  localparam int OFF_W = 6;

  localparam logic [OFF_W-1:0] OFF_ID_HI  = 6'h00;
  localparam logic [OFF_W-1:0] OFF_ID_LO  = 6'h04;
  localparam logic [OFF_W-1:0] OFF_BUSY   = 6'h08;
  localparam logic [OFF_W-1:0] OFF_RXCNT  = 6'h0C;
  localparam logic [OFF_W-1:0] OFF_TXCNT  = 6'h10;
  localparam logic [OFF_W-1:0] OFF_IRQ    = 6'h14;
  localparam logic [OFF_W-1:0] OFF_INFO   = 6'h18;
  localparam logic [OFF_W-1:0] OFF_RXDAT  = 6'h1C;
  localparam logic [OFF_W-1:0] OFF_TXDAT  = 6'h20;

  localparam int IRQ_TX_BIT   = 0;
  localparam int IRQ_RX_BIT   = 1;
  localparam int IRQ_TEST_BIT = 31;

  typedef struct packed {
    logic test;
    logic rx;
    logic tx;
  } irq_flags_t;

  function automatic logic [31:0] flags_to_word(irq_flags_t f);
    logic [31:0] w;
    w = '0;
    w[IRQ_TX_BIT]   = f.tx;
    w[IRQ_RX_BIT]   = f.rx;
    w[IRQ_TEST_BIT] = f.test;
    return w;
  endfunction
endpackage

// File: rtl/bnic_rx_buf.sv
module bnic_rx_buf #(
  parameter int MAX_FRAME = 1514,
  parameter int CNT_W     = $clog2(MAX_FRAME + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             busy,
  input  logic             in_valid,
  input  logic             in_first,
  input  logic             in_last,
  input  logic [7:0]       in_data,
  input  logic             pop,
  output logic             in_ready,
  output logic [CNT_W-1:0] count,
  output logic [7:0]       pop_byte,
  output logic             commit
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_FRAME);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [7:0]       mem [MAX_FRAME];
  logic             cap_q, cap_d;
  logic [CNT_W-1:0] widx_q, widx_d;
  logic [CNT_W-1:0] ridx_q, ridx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [7:0]       pop_q;
  logic             wr_en;
  logic [CNT_W-1:0] wr_addr;
  logic [CNT_W-1:0] frame_len;
  logic             commit_c;

  assign in_ready = !busy && (cnt_q < CNT_MAX);

  always_comb begin
    cap_d     = cap_q;
    widx_d    = widx_q;
    ridx_d    = ridx_q;
    cnt_d     = cnt_q;
    wr_en     = 1'b0;
    wr_addr   = widx_q;
    frame_len = widx_q + ONE;
    commit_c  = 1'b0;
    // host pop side
    if (pop && (cnt_q != '0)) begin
      ridx_d = ridx_q + ONE;
      cnt_d  = cnt_q - ONE;
    end
    // stream capture side
    if (in_valid) begin
      if (in_first) begin
        if (in_ready) begin
          wr_en     = 1'b1;
          wr_addr   = '0;
          widx_d    = ONE;
          frame_len = ONE;
          commit_c  = in_last;
          cap_d     = !in_last;
        end else begin
          cap_d = 1'b0;
        end
      end else if (cap_q) begin
        if (widx_q < CNT_MAX) begin
          wr_en  = 1'b1;
          widx_d = widx_q + ONE;
        end
        if (in_last) begin
          cap_d    = 1'b0;
          commit_c = (widx_q < CNT_MAX - ONE);
        end
      end
    end
    if (soft_rst) begin
      cap_d    = 1'b0;
      widx_d   = '0;
      ridx_d   = '0;
      cnt_d    = '0;
      commit_c = 1'b0;
    end else if (commit_c) begin
      cnt_d  = frame_len;
      ridx_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= 1'b0;
      widx_q <= '0;
      ridx_q <= '0;
      cnt_q  <= '0;
    end else begin
      cap_q  <= cap_d;
      widx_q <= widx_d;
      ridx_q <= ridx_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= in_data;
    if (pop)   pop_q <= (cnt_q != '0) ? mem[ridx_q] : 8'h00;
  end

  assign count    = cnt_q;
  assign pop_byte = pop_q;
  assign commit   = commit_c;

  a_r4_count_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_MAX);
  a_r5_pop_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && cnt_q != '0 && !commit_c && !soft_rst) |=> (cnt_q == $past(cnt_q) - ONE));
  a_r5_empty_pop_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && cnt_q == '0 && !commit_c && !soft_rst) |=> (cnt_q == '0));
  a_r13_commit_loads_len: assert property (@(posedge clk) disable iff (!rst_n)
    commit_c |=> (cnt_q != '0 && ridx_q == '0));
endmodule

// File: rtl/bnic_tx_buf.sv
module bnic_tx_buf #(
  parameter int MAX_FRAME = 1514,
  parameter int CNT_W     = $clog2(MAX_FRAME + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             len_wr,
  input  logic [31:0]      len_val,
  input  logic             dat_wr,
  input  logic [7:0]       dat_byte,
  output logic [CNT_W-1:0] count,
  output logic             done,
  output logic             out_valid,
  output logic             out_first,
  output logic             out_last,
  output logic [7:0]       out_data
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_FRAME);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [7:0]       mem [MAX_FRAME];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] widx_q, widx_d;
  logic             em_act_q, em_act_d;
  logic [CNT_W-1:0] em_ptr_q, em_ptr_d;
  logic [CNT_W-1:0] em_len_q, em_len_d;
  logic             pend_q, pend_d;
  logic [CNT_W-1:0] pend_len_q, pend_len_d;
  logic             ov_q, ov_d, of_q, of_d, ol_q, ol_d;
  logic [7:0]       od_q;
  logic             rd_en;
  logic [CNT_W-1:0] next_idx;
  logic             done_c;

  always_comb begin
    cnt_d      = cnt_q;
    widx_d     = widx_q;
    em_act_d   = em_act_q;
    em_ptr_d   = em_ptr_q;
    em_len_d   = em_len_q;
    pend_d     = pend_q;
    pend_len_d = pend_len_q;
    ov_d       = 1'b0;
    of_d       = 1'b0;
    ol_d       = 1'b0;
    rd_en      = 1'b0;
    done_c     = 1'b0;
    next_idx   = widx_q + ONE;
    // emitter: one byte per cycle
    if (em_act_q) begin
      rd_en    = 1'b1;
      ov_d     = 1'b1;
      of_d     = (em_ptr_q == '0);
      ol_d     = (em_ptr_q == em_len_q - ONE);
      em_ptr_d = em_ptr_q + ONE;
      if (ol_d) begin
        if (pend_q) begin
          em_ptr_d = '0;
          em_len_d = pend_len_q;
          pend_d   = 1'b0;
        end else begin
          em_act_d = 1'b0;
        end
      end
    end
    // host side
    if (len_wr) begin
      cnt_d  = (len_val <= 32'(MAX_FRAME)) ? len_val[CNT_W-1:0] : '0;
      widx_d = '0;
    end
    if (dat_wr) begin
      if (next_idx >= CNT_MAX || next_idx == cnt_q) begin
        done_c = 1'b1;
        cnt_d  = '0;
        widx_d = '0;
        if (em_act_d) begin
          pend_d     = 1'b1;
          pend_len_d = next_idx;
        end else begin
          em_act_d = 1'b1;
          em_ptr_d = '0;
          em_len_d = next_idx;
        end
      end else begin
        widx_d = next_idx;
      end
    end
    if (soft_rst) begin
      cnt_d    = '0;
      widx_d   = '0;
      em_act_d = 1'b0;
      pend_d   = 1'b0;
      ov_d     = 1'b0;
      of_d     = 1'b0;
      ol_d     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      widx_q     <= '0;
      em_act_q   <= 1'b0;
      em_ptr_q   <= '0;
      em_len_q   <= '0;
      pend_q     <= 1'b0;
      pend_len_q <= '0;
      ov_q       <= 1'b0;
      of_q       <= 1'b0;
      ol_q       <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      widx_q     <= widx_d;
      em_act_q   <= em_act_d;
      em_ptr_q   <= em_ptr_d;
      em_len_q   <= em_len_d;
      pend_q     <= pend_d;
      pend_len_q <= pend_len_d;
      ov_q       <= ov_d;
      of_q       <= of_d;
      ol_q       <= ol_d;
    end
  end

  always_ff @(posedge clk) begin
    if (dat_wr) mem[widx_q] <= dat_byte;
    if (rd_en)  od_q <= mem[em_ptr_q];
  end

  assign count     = cnt_q;
  assign done      = done_c;
  assign out_valid = ov_q;
  assign out_first = of_q;
  assign out_last  = ol_q;
  assign out_data  = od_q;

  a_r7_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    widx_q < CNT_MAX);
  a_r7_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (done_c && !len_wr) |=> (cnt_q == '0 && widx_q == '0));
  a_r8_marks_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_first || out_last) |-> out_valid);
  a_r8_emit_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done_c && !soft_rst) |=> em_act_q);
endmodule

// File: rtl/bytewise_nic.sv
module bytewise_nic #(
  parameter int          MAX_FRAME = 1514,
  parameter int          BUS_AW    = 8,
  parameter logic [31:0] ID_HI     = 32'h4E494331,
  parameter logic [31:0] ID_LO     = 32'h42595445
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  input  logic              rxs_valid,
  input  logic              rxs_first,
  input  logic              rxs_last,
  input  logic [7:0]        rxs_data,
  output logic              rxs_ready,
  output logic              txs_valid,
  output logic              txs_first,
  output logic              txs_last,
  output logic [7:0]        txs_data
);
  import bnic_pkg::*;

  localparam int CNT_W = $clog2(MAX_FRAME + 1);

  logic [OFF_W-1:0] off;
  logic             wr_ic, rd_ic, wr_txcnt, wr_txdat, rd_rxdat, soft_rst;
  irq_flags_t       flags_q, flags_d;
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] rx_count, tx_count;
  logic [7:0]       pop_byte;
  logic             rx_commit, tx_done;
  logic [31:0]      rd_val, rdata_q;
  logic             rsel_q;
  logic             unused_addr;

  assign off         = bus_addr[OFF_W-1:0];
  assign unused_addr = ^bus_addr;
  assign wr_ic       = bus_wr && (off == OFF_IRQ);
  assign wr_txcnt    = bus_wr && (off == OFF_TXCNT);
  assign wr_txdat    = bus_wr && (off == OFF_TXDAT);
  assign rd_ic       = bus_rd && (off == OFF_IRQ);
  assign rd_rxdat    = bus_rd && (off == OFF_RXDAT);
  assign soft_rst    = wr_ic && !bus_wdata[IRQ_TX_BIT] && !bus_wdata[IRQ_RX_BIT]
                       && bus_wdata[IRQ_TEST_BIT];

  bnic_rx_buf #(.MAX_FRAME(MAX_FRAME), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .busy(busy_q),
    .in_valid(rxs_valid), .in_first(rxs_first), .in_last(rxs_last),
    .in_data(rxs_data), .pop(rd_rxdat), .in_ready(rxs_ready),
    .count(rx_count), .pop_byte(pop_byte), .commit(rx_commit)
  );

  bnic_tx_buf #(.MAX_FRAME(MAX_FRAME), .CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .len_wr(wr_txcnt), .len_val(bus_wdata),
    .dat_wr(wr_txdat), .dat_byte(bus_wdata[7:0]),
    .count(tx_count), .done(tx_done),
    .out_valid(txs_valid), .out_first(txs_first), .out_last(txs_last),
    .out_data(txs_data)
  );

  // flag and busy next state
  always_comb begin
    flags_d = flags_q;
    busy_d  = busy_q;
    if (rd_ic) flags_d.test = 1'b0;
    if (wr_ic) begin
      if (bus_wdata[IRQ_TX_BIT])        flags_d.tx = 1'b0;
      else if (bus_wdata[IRQ_RX_BIT])   flags_d.rx = 1'b0;
      else if (bus_wdata[IRQ_TEST_BIT]) flags_d = '{test: 1'b1, rx: 1'b0, tx: 1'b0};
      busy_d = |flags_d;
    end
    if (tx_done) begin
      flags_d.tx = 1'b1;
      busy_d     = 1'b1;
    end
    if (rx_commit) begin
      flags_d.rx = 1'b1;
      busy_d     = 1'b1;
    end
  end

  always_comb begin
    case (off)
      OFF_ID_HI: rd_val = ID_HI;
      OFF_ID_LO: rd_val = ID_LO;
      OFF_BUSY:  rd_val = {31'b0, busy_q};
      OFF_RXCNT: rd_val = 32'(rx_count);
      OFF_TXCNT: rd_val = 32'(tx_count);
      OFF_IRQ:   rd_val = flags_to_word(flags_q);
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      busy_q  <= 1'b1;
      rdata_q <= '0;
      rsel_q  <= 1'b0;
    end else begin
      flags_q <= flags_d;
      busy_q  <= busy_d;
      if (bus_rd) begin
        rdata_q <= rd_val;
        rsel_q  <= rd_rxdat;
      end
    end
  end

  assign bus_rdata = rsel_q ? {24'b0, pop_byte} : rdata_q;
  assign irq       = |flags_q;

  a_r10_busy_tracks_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ic && !rx_commit) |=> (busy_q == irq));
  a_r9_tx_ack_first: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ic && bus_wdata[IRQ_TX_BIT]) |=> !flags_q.tx);
  a_r9_rx_ack_second: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ic && !bus_wdata[IRQ_TX_BIT] && bus_wdata[IRQ_RX_BIT] && !rx_commit) |=> !flags_q.rx);
  a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (flags_q.test && !flags_q.rx && !flags_q.tx && rx_count == '0 && tx_count == '0));
  a_r11_read_clears_test: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ic && !bus_wr) |=> !flags_q.test);
  a_r13_commit_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rx_commit |=> (flags_q.rx && busy_q));
endmodule

// File: tb/test_bytewise_nic.sv
`timescale 1ns/1ps
module test_bytewise_nic;
  logic        clk, rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq;
  logic        rxs_valid, rxs_first, rxs_last, rxs_ready;
  logic [7:0]  rxs_data;
  logic        txs_valid, txs_first, txs_last;
  logic [7:0]  txs_data;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;
  logic [9:0] exp_q[$];

  bytewise_nic i_bytewise_nic (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .rxs_valid(rxs_valid), .rxs_first(rxs_first), .rxs_last(rxs_last),
    .rxs_data(rxs_data), .rxs_ready(rxs_ready),
    .txs_valid(txs_valid), .txs_first(txs_first), .txs_last(txs_last), .txs_data(txs_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] pat(int seed, int i);
    return 8'((seed + i * 13) & 255);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic bw(logic [7:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(logic [7:0] a, logic [31:0] exp, string tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic rx_send(int len, int seed);
    for (int i = 0; i < len; i++) begin
      rxs_valid = 1'b1; rxs_first = (i == 0); rxs_last = (i == len - 1);
      rxs_data = pat(seed, i);
      @(negedge clk);
    end
    rxs_valid = 1'b0; rxs_first = 1'b0; rxs_last = 1'b0;
  endtask

  // scoreboard driver side: expected transmit items
  task automatic tx_push(int len, int seed);
    for (int i = 0; i < len; i++)
      exp_q.push_back({(i == 0), (i == len - 1), pat(seed, i)});
  endtask

  task automatic drain();
    for (int k = 0; k < 4000 && exp_q.size() != 0; k++) @(negedge clk);
    chk("R8 all expected bytes emitted", exp_q.size(), 0);
  endtask

  // scoreboard monitor side
  always @(negedge clk) begin
    if (rst_n && txs_valid) begin
      if (exp_q.size() == 0) begin
        chk("R8 unexpected transmit byte", {22'b0, txs_first, txs_last, txs_data}, 32'hFFFF_FFFF);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        chk("R8 transmit stream byte", {22'b0, txs_first, txs_last, txs_data}, {22'b0, e});
      end
    end
  end

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    rxs_valid = 0; rxs_first = 0; rxs_last = 0; rxs_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd_chk(8'h08, 1, "R10 busy after reset");
    rd_chk(8'h14, 0, "R12 flags after reset");
    chk("R12 irq low after reset", irq, 0);
    rd_chk(8'h00, 32'h4E494331, "R1 id word high");
    rd_chk(8'h04, 32'h42595445, "R1 id word low");
    rd_chk(8'h40, 32'h4E494331, "R1 alias of 0x00");
    rd_chk(8'h44, 32'h42595445, "R1 alias of 0x04");
    rd_chk(8'h18, 0, "R2 info reads zero");
    rd_chk(8'h20, 0, "R2 tx port reads zero");
    rd_chk(8'h3C, 0, "R2 unmapped reads zero");

    bw(8'h14, 0);
    rd_chk(8'h08, 0, "R10 busy cleared by flag write");
    chk("R3 ready when idle", rxs_ready, 1);
    bw(8'h0C, 5); bw(8'h08, 1); bw(8'h00, 0);
    rd_chk(8'h0C, 0, "R2 rx count write ignored");
    rd_chk(8'h08, 0, "R2 busy write ignored");
    rd_chk(8'h00, 32'h4E494331, "R2 id write ignored");

    rx_send(5, 10);
    rd_chk(8'h0C, 5, "R4 rx count after commit");
    rd_chk(8'h08, 1, "R4 busy after commit");
    rd_chk(8'h14, 2, "R4 rx-done flag");
    chk("R12 irq with rx-done", irq, 1);
    chk("R3 ready low while busy", rxs_ready, 0);
    rx_send(3, 50);
    rd_chk(8'h0C, 5, "R3 refused frame dropped");
    for (int i = 0; i < 5; i++) rd_chk(8'h1C, {24'b0, pat(10, i)}, "R5 R14 rx byte");
    rd_chk(8'h1C, 0, "R5 empty read zero");
    rd_chk(8'h0C, 0, "R5 count at zero");

    bw(8'h14, 2);
    rd_chk(8'h14, 0, "R9 rx-done cleared");
    rd_chk(8'h08, 0, "R10 busy clear");
    chk("R12 irq low", irq, 0);

    rx_send(1514, 3);
    rd_chk(8'h0C, 0, "R4 oversize frame dropped");
    rd_chk(8'h14, 0, "R4 oversize sets no flag");
    rx_send(1513, 7);
    rd_chk(8'h0C, 1513, "R4 largest frame kept");
    rd_chk(8'h1C, {24'b0, pat(7, 0)}, "R5 first byte");
    rd_chk(8'h1C, {24'b0, pat(7, 1)}, "R5 second byte");
    bw(8'h14, 2);

    // R13: commit on the same cycle as a data-port read
    for (int i = 0; i < 4; i++) begin
      rxs_valid = 1; rxs_first = (i == 0); rxs_last = (i == 3); rxs_data = pat(90, i);
      if (i == 3) begin bus_addr = 8'h1C; bus_rd = 1; end
      @(negedge clk);
      bus_rd = 0;
    end
    rxs_valid = 0; rxs_first = 0; rxs_last = 0;
    rd_chk(8'h0C, 4, "R13 count from colliding commit");
    for (int i = 0; i < 4; i++) rd_chk(8'h1C, {24'b0, pat(90, i)}, "R13 new frame bytes");
    bw(8'h14, 2);
    rd_chk(8'h08, 0, "R10 busy clear again");

    // R13: commit on the same cycle as a tx-done acknowledge
    tx_push(2, 30);
    @(negedge clk);
    fork
      rx_send(6, 60);
      begin
        @(negedge clk);
        bw(8'h10, 2);
        bw(8'h20, {24'h0, pat(30, 0)});
        bw(8'h20, {24'h0, pat(30, 1)});
        @(negedge clk);
        bw(8'h14, 1);
      end
    join
    rd_chk(8'h14, 2, "R13 rx-done kept, tx-done cleared");
    rd_chk(8'h08, 1, "R13 busy after collision");
    rd_chk(8'h0C, 6, "R13 R3 frame accepted at first byte");
    rd_chk(8'h10, 0, "R7 tx count cleared");
    drain();

    bw(8'h10, 2000);
    rd_chk(8'h10, 0, "R6 over-limit count loads zero");
    bw(8'h10, 1514);
    rd_chk(8'h10, 1514, "R6 limit count loads");
    bw(8'h10, 1515);
    rd_chk(8'h10, 0, "R6 one past limit loads zero");

    tx_push(1514, 5);
    for (int i = 0; i < 1514; i++) bw(8'h20, 32'hA5A5_A500 | 32'(pat(5, i)));
    rd_chk(8'h10, 0, "R7 count clear after cap");
    rd_chk(8'h14, 3, "R7 tx-done set");
    drain();

    bw(8'h10, 3);
    bw(8'h20, 32'h0000_00EE);
    bw(8'h10, 2);
    tx_push(2, 77);
    bw(8'h20, {24'h0, pat(77, 0)});
    bw(8'h20, {24'h0, pat(77, 1)});
    drain();

    bw(8'h14, 3);
    rd_chk(8'h14, 2, "R9 bit0 wins over bit1");
    bw(8'h14, 0);
    rd_chk(8'h14, 2, "R9 zero write no change");
    rd_chk(8'h08, 1, "R10 busy with flag left");
    bw(8'h14, 32'h8000_0002);
    rd_chk(8'h14, 0, "R9 bit1 wins over bit31");
    rd_chk(8'h0C, 6, "R9 no reset from bit1 write");
    rd_chk(8'h08, 0, "R10 busy after last flag cleared");

    bw(8'h10, 9);
    bw(8'h14, 32'h8000_0000);
    chk("R12 irq from test flag", irq, 1);
    rd_chk(8'h14, 32'h8000_0000, "R11 test flag reads set");
    rd_chk(8'h08, 1, "R10 busy after soft reset");
    rd_chk(8'h14, 0, "R11 test flag cleared by read");
    rd_chk(8'h0C, 0, "R9 soft reset rx count");
    rd_chk(8'h10, 0, "R9 soft reset tx count");
    bw(8'h14, 0);
    rd_chk(8'h08, 0, "R10 busy after zero write");
    chk("R8 queue empty at end", exp_q.size(), 0);
    report();
  end
endmodule